// File: doc/BRIEF.md
# Multi-Mode Timer with Capture/Compare Channels

This block is a 16-bit timer with three capture/compare channels. A small register bus sets it up. One control word picks the count source, a prescaler of 1, 2, 4 or 8 and one of four count modes: halted, up to the channel 0 value, free-running, or up to the channel 0 value and back down. The control word also clears the counter and holds the overflow enable and the overflow flag.

Each channel works in one of two modes. In capture mode it copies the counter when a chosen edge appears on a selected input. The capture can happen at once or wait for the next timer tick. In compare mode it flags the tick on which the counter lands on the channel value, and it drives an output pin through one of eight behaviours. Some of these behaviours combine the channel's own match with the period event, which is the counter reaching the channel 0 value, or reaching zero in up/down mode. A vector register gives the highest-priority pending source, and reading it clears that source.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset every register reads 0. The counter is halted, every channel output is 0 and both interrupt lines are 0.
- R2: Control bits 9:8 pick the count source: 0 is rising edges of `extClk`, 1 is `slowTick`, 2 is `sysTick`, 3 is falling edges of `extClk`. Control bits 7:6 = n make the counter advance once per 2^n source events.
- R3: With control bits 5:4 = 0 the counter holds its value. Source events do not change it, but a bus write to the counter register (address 1) still loads it.
- R4: With control bits 5:4 = 2 the counter steps by one on each tick. When it wraps from 0xFFFF to 0 it sets the overflow flag, which is control bit 0.
- R5: With control bits 5:4 = 1 the counter runs 0..C0, where C0 is the channel 0 value at address 8. The tick that returns it to 0 sets the overflow flag.
- R6: With control bits 5:4 = 3 the counter climbs to C0, then falls to 0 and climbs again. The overflow flag is set only on the tick that brings the count down to 0.
- R7: Writing 1 to control bit 2 zeroes the counter and the prescaler. Bit 2 always reads back as 0.
- R8: A channel in capture mode (channel control bit 8 = 1) copies the counter into its value register on the edges picked by bits 15:14 (01 rising, 10 falling, 11 both). The input is picked by bits 13:12 (0 input A, 1 input B, 2 low, 3 high). A capture sets flag bit 0. Bit 3 reads the selected input directly.
- R9: With channel control bit 11 set, a detected edge waits. It is captured on the next timer tick and takes the count held just before that tick.
- R10: A capture that arrives while flag bit 0 is still set sets overflow bit 1. Bit 1 stays set until software rewrites it, even after further captures and vector reads.
- R11: In compare mode, the tick on which the counter becomes equal to the channel value sets flag bit 0. On that same tick the selected input is latched into bit 10.
- R12: Channel control bits 7:5 pick the output behaviour. 0 follows bit 2. 1 sets on a match. 4 toggles on a match. 5 clears on a match. 2, 3, 6 and 7 take a first action on their own match (toggle, set, toggle, clear) and a second on the period event (clear, clear, set, set).
- R13: The vector register (address 2) reads 2 for channel 1, 4 for channel 2, 10 for overflow, and 0 if nothing is pending. A source is pending when its flag and its enable bit (bit 4 for a channel, control bit 1 for overflow) are both set. Priority is in that order. A bus read of the vector clears the source it reports. `irqMain` is the OR of those pending sources, and `irqCh0` is channel 0 flag AND channel 0 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (needed for the read-clear of the vector) |
| busAddr | input | 4 | Register address: 0 control, 1 count, 2 vector, 4+k channel k control, 8+k channel k value |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| extClk | input | 1 | External count clock level, synchronous to clk |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| sysTick | input | 1 | One-cycle pulse per subsystem-clock period |
| capInA | input | 3 | Input A of each channel |
| capInB | input | 3 | Input B of each channel |
| chOut | output | 3 | Output pin of each channel |
| irqCh0 | output | 1 | Channel 0 interrupt |
| irqMain | output | 1 | Interrupt for channels 1..2 and overflow |

## Verification
The hardest case to reach is a pending synchronous capture. The edge has already been seen but the timer has not ticked yet. To create it, the bench runs the counter in free-running mode, feeds no source events, and moves the channel input. It reads the value register, which must not have changed. Then it sends one source event and checks that the captured value is the count from before that tick. A second edge while the flag is still set covers the capture overflow. Setting two flags together covers the vector priority.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0, MODE_UP = 2'd1, MODE_CONT = 2'd2, MODE_UPDN = 2'd3
  } cntMode_e;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0, SRC_SLOW = 2'd1, SRC_SYS = 2'd2, SRC_EXTN = 2'd3
  } clkSrc_e;

  typedef enum logic [2:0] {
    OM_BIT = 3'd0, OM_SET = 3'd1, OM_TGLRST = 3'd2, OM_SETRST = 3'd3,
    OM_TGL = 3'd4, OM_RST = 3'd5, OM_TGLSET = 3'd6, OM_RSTSET = 3'd7
  } outMode_e;

  localparam int REG_W = 16;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_VEC   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CHCTL = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_CHVAL = 4'd8;
  localparam logic [REG_W-1:0]  VEC_OVF    = 16'd10;

  // strobes from the count control to the channel datapath
  typedef struct packed {
    logic tick;       // counter advances this cycle
    logic periodEvt;  // second-action event for two-part output modes
  } tmrStrb_t;
endpackage

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              extClk,
  input  logic              slowTick,
  input  logic              sysTick,
  input  logic [CNT_W-1:0]  ccr0,
  input  logic              ovfClr,
  output logic [REG_W-1:0]  ctlWord,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cntNext,
  output tmrStrb_t          strb,
  output logic              ovfPend
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  clkSrc_e    srcSel;
  logic [1:0] divSel;
  cntMode_e   mode;
  logic       ovfIe, ovfFlag, extPrev, dirUp, dirNext, wrap, srcEvt;
  logic [DIV_W-1:0] divCnt, divMask;
  logic unusedCtlBits;

  wire wrCtl  = busWr && (busAddr == ADDR_CTL);
  wire wrCnt  = busWr && (busAddr == ADDR_CNT);
  wire clrReq = wrCtl && busWdata[2];
  assign unusedCtlBits = ^{busWdata[15:10], busWdata[3]};

  always_comb begin
    unique case (srcSel)
      SRC_EXT:  srcEvt = extClk & ~extPrev;
      SRC_SLOW: srcEvt = slowTick;
      SRC_SYS:  srcEvt = sysTick;
      default:  srcEvt = ~extClk & extPrev;
    endcase
  end

  assign divMask = DIV_W'((1 << divSel) - 1);
  wire divTick = srcEvt && ((divCnt & divMask) == divMask);

  always_comb begin
    cntNext = cnt;
    dirNext = dirUp;
    wrap    = 1'b0;
    unique case (mode)
      MODE_UP: begin
        if (cnt >= ccr0) begin
          cntNext = '0;
          wrap    = 1'b1;
        end else cntNext = cnt + 1'b1;
      end
      MODE_CONT: begin
        cntNext = cnt + 1'b1;
        wrap    = (cnt == CNT_MAX);
      end
      MODE_UPDN: begin
        if (dirUp && cnt < ccr0) cntNext = cnt + 1'b1;
        else if (cnt == '0) begin
          cntNext = (ccr0 == '0) ? '0 : CNT_W'(1);
          dirNext = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
          wrap    = (cnt == CNT_W'(1));
          dirNext = (cnt == CNT_W'(1));
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    strb.tick = (mode != MODE_STOP) && divTick && !clrReq && !wrCnt;
    strb.periodEvt = strb.tick &&
                     ((mode == MODE_UPDN) ? wrap : (cntNext == ccr0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel  <= SRC_EXT;
      divSel  <= '0;
      mode    <= MODE_STOP;
      ovfIe   <= 1'b0;
      ovfFlag <= 1'b0;
      extPrev <= 1'b0;
      divCnt  <= '0;
      dirUp   <= 1'b1;
      cnt     <= '0;
    end else begin
      extPrev <= extClk;
      if (wrCtl) begin
        srcSel <= clkSrc_e'(busWdata[9:8]);
        divSel <= busWdata[7:6];
        mode   <= cntMode_e'(busWdata[5:4]);
        ovfIe  <= busWdata[1];
      end
      ovfFlag <= (strb.tick && wrap) | (wrCtl ? busWdata[0] : (ovfFlag & ~ovfClr));
      if (clrReq) divCnt <= '0;
      else if (srcEvt) divCnt <= divCnt + 1'b1;
      if (clrReq) begin
        cnt   <= '0;
        dirUp <= 1'b1;
      end else if (wrCnt) begin
        cnt <= busWdata[CNT_W-1:0];
      end else if (strb.tick) begin
        cnt   <= cntNext;
        dirUp <= dirNext;
      end
    end
  end

  assign ctlWord = {6'b0, srcSel, divSel, mode, 2'b00, ovfIe, ovfFlag};
  assign ovfPend = ovfFlag & ovfIe;
endmodule

// File: rtl/mmt_chan.sv
module mmt_chan
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtl,
  input  logic             wrVal,
  input  logic [REG_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cntNext,
  input  tmrStrb_t         strb,
  input  logic             inA,
  input  logic             inB,
  input  logic             flagClr,
  output logic [REG_W-1:0] ctlWord,
  output logic [CNT_W-1:0] val,
  output logic             outPin,
  output logic             pend
);
  logic [1:0] capEdge, inSel;
  logic       syncCap, sciQ, capMode, ie, outBit, cov, flag;
  logic       selIn, selPrev, capPend, outQ, outD;
  outMode_e   outMode;
  logic unusedWrBits;
  assign unusedWrBits = ^{wdata[10:9], wdata[3]};

  always_comb begin
    unique case (inSel)
      2'd0:    selIn = inA;
      2'd1:    selIn = inB;
      2'd2:    selIn = 1'b0;
      default: selIn = 1'b1;
    endcase
  end

  wire edgeHit = capMode && ((capEdge[0] && selIn && !selPrev) ||
                             (capEdge[1] && !selIn && selPrev));
  wire capNow  = syncCap ? (capPend && strb.tick) : edgeHit;
  wire cmpHit  = !capMode && strb.tick && (cntNext == val);

  always_comb begin
    outD = outQ;
    if (outMode == OM_BIT) outD = outBit;
    else if (cmpHit) begin
      unique case (outMode)
        OM_SET, OM_SETRST:            outD = 1'b1;
        OM_RST, OM_RSTSET:            outD = 1'b0;
        default:                      outD = ~outQ;
      endcase
    end else if (!capMode && strb.periodEvt) begin
      unique case (outMode)
        OM_TGLRST, OM_SETRST: outD = 1'b0;
        OM_TGLSET, OM_RSTSET: outD = 1'b1;
        default:              outD = outQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEdge <= '0;
      inSel   <= '0;
      syncCap <= 1'b0;
      sciQ    <= 1'b0;
      capMode <= 1'b0;
      outMode <= OM_BIT;
      ie      <= 1'b0;
      outBit  <= 1'b0;
      cov     <= 1'b0;
      flag    <= 1'b0;
      selPrev <= 1'b0;
      capPend <= 1'b0;
      outQ    <= 1'b0;
      val     <= '0;
    end else begin
      selPrev <= selIn;
      outQ    <= outD;
      if (wrCtl) begin
        capEdge <= wdata[15:14];
        inSel   <= wdata[13:12];
        syncCap <= wdata[11];
        capMode <= wdata[8];
        outMode <= outMode_e'(wdata[7:5]);
        ie      <= wdata[4];
        outBit  <= wdata[2];
      end
      if (cmpHit) sciQ <= selIn;
      if (edgeHit && syncCap) capPend <= 1'b1;
      else if (capNow) capPend <= 1'b0;
      flag <= capNow | cmpHit | (wrCtl ? wdata[0] : (flag & ~flagClr));
      cov  <= (capNow && flag) | (wrCtl ? wdata[1] : cov);
      if (capNow) val <= cnt;
      else if (wrVal) val <= wdata[CNT_W-1:0];
    end
  end

  assign ctlWord = {capEdge, inSel, syncCap, sciQ, 1'b0, capMode, outMode,
                    ie, selIn, outBit, cov, flag};
  assign outPin  = outQ;
  assign pend    = flag & ie;
endmodule

// File: rtl/mmt_datapath.sv
module mmt_datapath
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cntNext,
  input  tmrStrb_t          strb,
  input  logic              ovfPend,
  input  logic [REG_W-1:0]  ctlWord,
  input  logic [NUM_CH-1:0] capInA,
  input  logic [NUM_CH-1:0] capInB,
  output logic              ovfClr,
  output logic [CNT_W-1:0]  ccr0,
  output logic [NUM_CH-1:0] chOut,
  output logic [REG_W-1:0]  busRdata,
  output logic              irqCh0,
  output logic              irqMain
);
  logic [REG_W-1:0]  chCtl [NUM_CH];
  logic [CNT_W-1:0]  chVal [NUM_CH];
  logic [NUM_CH-1:0] pend, vecSel;
  logic [REG_W-1:0]  vecVal;
  logic              vecOvf;

  wire vecRd = busRd && (busAddr == ADDR_VEC);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    mmt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .wrCtl   (busWr && (busAddr == ADDR_CHCTL + ADDR_W'(k))),
      .wrVal   (busWr && (busAddr == ADDR_CHVAL + ADDR_W'(k))),
      .wdata   (busWdata),
      .cnt     (cnt),
      .cntNext (cntNext),
      .strb    (strb),
      .inA     (capInA[k]),
      .inB     (capInB[k]),
      .flagClr (vecRd && vecSel[k]),
      .ctlWord (chCtl[k]),
      .val     (chVal[k]),
      .outPin  (chOut[k]),
      .pend    (pend[k])
    );
  end

  // lowest channel number above 0 wins, overflow last
  always_comb begin
    vecVal = '0;
    vecSel = '0;
    vecOvf = ovfPend;
    if (ovfPend) vecVal = VEC_OVF;
    for (int k = NUM_CH - 1; k >= 1; k--) begin
      if (pend[k]) begin
        vecVal    = REG_W'(2 * k);
        vecSel    = '0;
        vecSel[k] = 1'b1;
        vecOvf    = 1'b0;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_CTL) busRdata = ctlWord;
    if (busAddr == ADDR_CNT) busRdata = REG_W'(cnt);
    if (busAddr == ADDR_VEC) busRdata = vecVal;
    for (int k = 0; k < NUM_CH; k++) begin
      if (busAddr == ADDR_CHCTL + ADDR_W'(k)) busRdata = chCtl[k];
      if (busAddr == ADDR_CHVAL + ADDR_W'(k)) busRdata = REG_W'(chVal[k]);
    end
  end

  assign ovfClr  = vecRd && vecOvf;
  assign ccr0    = chVal[0];
  assign irqCh0  = pend[0];
  assign irqMain = (|pend[NUM_CH-1:1]) | ovfPend;
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              extClk,
  input  logic              slowTick,
  input  logic              sysTick,
  input  logic [NUM_CH-1:0] capInA,
  input  logic [NUM_CH-1:0] capInB,
  output logic [NUM_CH-1:0] chOut,
  output logic              irqCh0,
  output logic              irqMain
);
  logic [REG_W-1:0] ctlWord;
  logic [CNT_W-1:0] cnt, cntNext, ccr0;
  tmrStrb_t         strb;
  logic             ovfPend, ovfClr;

  mmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .extClk(extClk), .slowTick(slowTick),
    .sysTick(sysTick), .ccr0(ccr0), .ovfClr(ovfClr), .ctlWord(ctlWord),
    .cnt(cnt), .cntNext(cntNext), .strb(strb), .ovfPend(ovfPend)
  );

  mmt_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .cnt(cnt), .cntNext(cntNext),
    .strb(strb), .ovfPend(ovfPend), .ctlWord(ctlWord), .capInA(capInA),
    .capInB(capInB), .ovfClr(ovfClr), .ccr0(ccr0), .chOut(chOut),
    .busRdata(busRdata), .irqCh0(irqCh0), .irqMain(irqMain)
  );
endmodule

// File: rtl/multi_mode_timer_chk.sv
module multi_mode_timer_chk
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWdata,
  input logic [REG_W-1:0]  busRdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ccr0,
  input logic [REG_W-1:0]  ctlWord,
  input logic              tick
);
  wire [1:0] mode = ctlWord[5:4];

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !busWr) |=> $stable(cnt));

  p_cont_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && tick) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && tick && cnt >= ccr0) |=> (cnt == '0 && ctlWord[0]));

  p_updn_ceiling_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && tick && cnt <= ccr0 &&
     !(busWr && busAddr == ADDR_CHVAL)) |=> cnt <= ccr0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CTL && busWdata[2]) |=> (cnt == '0 && !ctlWord[2]));

  p_vec_legal_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_VEC) |-> (busRdata == 16'd0 || busRdata == 16'd2 ||
                               busRdata == 16'd4 || busRdata == 16'd10));
endmodule

bind multi_mode_timer multi_mode_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .cnt(cnt), .ccr0(ccr0),
  .ctlWord(ctlWord), .tick(strb.tick)
);

// File: tb/multi_mode_timer_tb.sv
module multi_mode_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        extClk = 1'b0, slowTick = 1'b0, sysTick = 1'b0;
  logic [2:0]  capInA = '0, capInB = '0;
  logic [2:0]  chOut;
  logic        irqCh0, irqMain;
  int          errors = 0, checks = 0;

  always #10 clk = ~clk;

  multi_mode_timer u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk),
    .slowTick(slowTick), .sysTick(sysTick), .capInA(capInA), .capInB(capInB),
    .chOut(chOut), .irqCh0(irqCh0), .irqMain(irqMain)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pulseSys(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sysTick = 1'b1;
      @(negedge clk) sysTick = 1'b0;
    end
  endtask

  task automatic pulseSlow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slowTick = 1'b1;
      @(negedge clk) slowTick = 1'b0;
    end
  endtask

  task automatic expectCnt(input string req, input int exp);
    logic [15:0] d;
    rdReg(4'd1, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rdReg(4'd0, d); check("R1 ctl", d, 0);
    rdReg(4'd1, d); check("R1 cnt", d, 0);
    rdReg(4'd2, d); check("R1 vec", d, 0);
    rdReg(4'd5, d); check("R1 cctl1", d, 0);
    check("R1 outs", {irqMain, irqCh0, chOut}, 0);
  endtask

  task automatic t_clock_src;
    wrReg(4'd0, 16'h02A4);             // sys, div4, continuous, clear
    pulseSys(12);
    expectCnt("R2 div4", 3);
    wrReg(4'd0, 16'h0124);             // slow, div1, continuous, clear
    pulseSys(3);
    expectCnt("R2 other source ignored", 0);
    pulseSlow(2);
    expectCnt("R2 slow source", 2);
    wrReg(4'd0, 16'h0324);             // inverted external
    @(negedge clk) extClk = 1'b1;
    @(negedge clk);
    expectCnt("R2 rising ignored when inverted", 0);
    @(negedge clk) extClk = 1'b0;
    @(negedge clk);
    expectCnt("R2 falling counted", 1);
  endtask

  task automatic t_stop_clear;
    logic [15:0] d;
    wrReg(4'd0, 16'h0200);
    wrReg(4'd1, 16'd7);
    pulseSys(4);
    expectCnt("R3 stop hold", 7);
    wrReg(4'd0, 16'h0204);
    expectCnt("R7 clear", 0);
    rdReg(4'd0, d); check("R7 clear bit reads 0", d, 16'h0200);
  endtask

  task automatic t_cont;
    logic [15:0] d;
    wrReg(4'd1, 16'hFFFE);
    wrReg(4'd0, 16'h0222);             // sys, continuous, overflow enable
    pulseSys(1);
    rdReg(4'd0, d); check("R4 no flag before wrap", d[0], 0);
    expectCnt("R4 count FFFF", 16'hFFFF);
    pulseSys(1);
    expectCnt("R4 wrap", 0);
    rdReg(4'd0, d); check("R4 flag on wrap", d[0], 1);
    check("R13 irqMain overflow", irqMain, 1);
    rdReg(4'd2, d); check("R13 vector overflow", d, 10);
    rdReg(4'd0, d); check("R13 read clears overflow", d[0], 0);
    check("R13 irqMain drops", irqMain, 0);
  endtask

  task automatic t_up;
    logic [15:0] d;
    wrReg(4'd8, 16'd3);
    wrReg(4'd0, 16'h0214);
    for (int i = 1; i <= 3; i++) begin
      pulseSys(1);
      expectCnt("R5 up count", i);
      rdReg(4'd0, d); check("R5 no early flag", d[0], 0);
    end
    pulseSys(1);
    expectCnt("R5 wrap to 0", 0);
    rdReg(4'd0, d); check("R5 flag on wrap", d[0], 1);
  endtask

  task automatic t_updown;
    logic [15:0] d;
    int seq[7] = '{1, 2, 3, 2, 1, 0, 1};
    wrReg(4'd0, 16'h0234);
    for (int i = 0; i < 7; i++) begin
      pulseSys(1);
      expectCnt("R6 up/down count", seq[i]);
      if (i == 4) begin
        rdReg(4'd0, d); check("R6 no flag at 1", d[0], 0);
      end
      if (i == 5) begin
        rdReg(4'd0, d); check("R6 flag at zero", d[0], 1);
      end
    end
  endtask

  task automatic t_capture;
    logic [15:0] d;
    wrReg(4'd0, 16'h0200);             // stopped
    wrReg(4'd1, 16'd5);
    wrReg(4'd5, 16'h4110);             // rising, input A, capture, ie
    @(negedge clk) capInA[1] = 1'b1;
    @(negedge clk);
    rdReg(4'd9, d); check("R8 captured value", d, 5);
    rdReg(4'd5, d);
    check("R8 flag", d[0], 1);
    check("R8 raw input bit", d[3], 1);
    check("R10 no overflow yet", d[1], 0);
    wrReg(4'd1, 16'd6);
    @(negedge clk) capInA[1] = 1'b0;
    @(negedge clk);
    rdReg(4'd9, d); check("R8 falling edge ignored", d, 5);
    @(negedge clk) capInA[1] = 1'b1;
    @(negedge clk);
    rdReg(4'd9, d); check("R8 second capture", d, 6);
    rdReg(4'd5, d); check("R10 overflow set", d[1], 1);
    rdReg(4'd2, d); check("R13 vector ch1", d, 2);
    rdReg(4'd5, d);
    check("R13 vector read clears ch1", d[0], 0);
    check("R10 overflow kept after vector read", d[1], 1);
    wrReg(4'd1, 16'd7);
    @(negedge clk) capInA[1] = 1'b0;
    @(negedge clk) capInA[1] = 1'b1;
    @(negedge clk);
    rdReg(4'd5, d); check("R10 overflow sticky", d[1], 1);
    rdReg(4'd9, d); check("R8 third capture", d, 7);
    wrReg(4'd5, 16'h0000);
    capInA[1] = 1'b0;
  endtask

  task automatic t_sync_vec;
    logic [15:0] d;
    wrReg(4'd0, 16'h0220);             // sys, continuous
    wrReg(4'd1, 16'd10);
    wrReg(4'd6, 16'hD910);             // both edges, input B, sync, capture, ie
    @(negedge clk) capInB[2] = 1'b1;
    @(negedge clk);
    rdReg(4'd10, d); check("R9 no capture before tick", d, 0);
    rdReg(4'd6, d);  check("R9 no flag before tick", d[0], 0);
    pulseSys(1);
    rdReg(4'd10, d); check("R9 captured pre-tick count", d, 10);
    rdReg(4'd6, d);  check("R9 flag after tick", d[0], 1);
    expectCnt("R9 counter advanced", 11);
    wrReg(4'd5, 16'h0011);             // ch1 flag + ie by software
    rdReg(4'd2, d); check("R13 priority ch1", d, 2);
    rdReg(4'd2, d); check("R13 then ch2", d, 4);
    rdReg(4'd2, d); check("R13 then none", d, 0);
    wrReg(4'd4, 16'h0011);
    check("R13 irqCh0", irqCh0, 1);
    rdReg(4'd2, d); check("R13 ch0 not in vector", d, 0);
    wrReg(4'd4, 16'h0000);
    wrReg(4'd6, 16'h0000);
  endtask

  task automatic t_compare;
    logic [15:0] d;
    wrReg(4'd0, 16'h0204);
    wrReg(4'd9, 16'd2);
    wrReg(4'd5, 16'h0030);             // compare, set mode, ie
    capInA[1] = 1'b1;
    wrReg(4'd0, 16'h0220);
    pulseSys(1);
    rdReg(4'd5, d); check("R11 no flag before match", d[0], 0);
    check("R12 set mode before match", chOut[1], 0);
    pulseSys(1);
    rdReg(4'd5, d);
    check("R11 flag on match", d[0], 1);
    check("R11 latched input", d[10], 1);
    check("R12 set mode on match", chOut[1], 1);
    capInA[1] = 1'b0;
  endtask

  task automatic t_outmodes;
    wrReg(4'd8, 16'd5);
    wrReg(4'd10, 16'd2);
    wrReg(4'd6, 16'h0040);             // toggle/reset
    wrReg(4'd5, 16'h00E0);             // reset/set
    wrReg(4'd0, 16'h0214);             // up mode, clear
    pulseSys(2);
    check("R12 toggle/reset first action", chOut[2], 1);
    check("R12 reset/set first action", chOut[1], 0);
    pulseSys(3);
    check("R12 toggle/reset second action", chOut[2], 0);
    check("R12 reset/set second action", chOut[1], 1);
    pulseSys(3);
    check("R12 toggle again", chOut[2], 1);
    wrReg(4'd6, 16'h0004);
    @(negedge clk);
    check("R12 mode 0 follows bit high", chOut[2], 1);
    wrReg(4'd6, 16'h0000);
    @(negedge clk);
    check("R12 mode 0 follows bit low", chOut[2], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_clock_src();
    t_stop_clear();
    t_cont();
    t_up();
    t_updown();
    t_capture();
    t_sync_vec();
    t_compare();
    t_outmodes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule